// File: doc/BRIEF.md
# Coalescing Write-Through Store Buffer

This block sits next to the private first-level cache of a compute unit that keeps coherence in software. Data stores go into a small associative buffer and stay there. A later store to a word that is already held merges into the same entry, one byte at a time, so a word written many times costs a single transfer to the shared second-level cache. The buffer sends its entries downstream, oldest first, in two cases: a release with global scope asks for it, or the buffer has filled. In the second case it frees one slot at a time.

Synchronization requests carry a scope flag. A global release empties the buffer. It then waits until the shared cache has acknowledged every write-through and only then reports completion. A global acquire sends one strobe that clears every valid bit in the first-level cache. Operations with local scope stay inside the compute unit: a local release completes at once without draining, and a local acquire leaves the cache alone. The shared cache, the data array and the interconnect sit outside this block.

Top module: `wt_coalesce_buf`

## Requirements
- R1: After reset, `st_ready` is 1 and `wt_valid`, `rel_done` and `l1_inval` are 0.
- R2: Accepted stores produce no write-through while the buffer holds fewer than DEPTH entries and no global release is in progress.
- R3: A store whose word address matches a held entry merges into that entry. Each byte whose enable bit (bit b covers data bits 8b+7..8b) is set takes the newer value, and the other bytes keep their earlier value. The entry leaves as one write-through whose byte enables are the OR of the merged enables.
- R4: Entries leave in the order they were first allocated.
- R5: After a global release, `rel_done` pulses for one cycle in the first cycle in which the buffer is empty and no write-through is unacknowledged. With an empty buffer and nothing outstanding, this is the cycle after the request.
- R6: From the cycle after a global release is accepted until the cycle after `rel_done`, `st_ready` is 0.
- R7: A local release (`rel_global`=0) makes `rel_done` pulse in the next cycle. It sends no write-through and does not wait for acknowledgements.
- R8: A global acquire makes `l1_inval` pulse for exactly one cycle in the next cycle. A local acquire never raises it.
- R9: While the buffer holds DEPTH entries, the oldest entry is offered downstream. A store that misses waits with `st_ready`=0 until a slot is freed. A store that hits an entry other than the one being offered is accepted.
- R10: When a store targets a word whose entry has already been written through, the store allocates a new entry, and that word reaches the shared cache a second time.
- R11: No more than MAX_OUT write-throughs are ever accepted without an acknowledgement.
- R12: While `wt_valid` is 1 and `wt_ready` is 0, the offered address, data and enables stay unchanged. A store that hits the offered entry waits until that entry has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Store request valid |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| acq_valid | input | 1 | Acquire request (one-cycle pulse) |
| acq_global | input | 1 | Acquire scope: 1 global, 0 local |
| rel_valid | input | 1 | Release request (one-cycle pulse) |
| rel_global | input | 1 | Release scope: 1 global, 0 local |
| rel_done | output | 1 | Release complete pulse |
| l1_inval | output | 1 | Flash-invalidate strobe to the first-level valid bits |
| wt_valid | output | 1 | Write-through offered downstream |
| wt_ready | input | 1 | Downstream accepts the write-through |
| wt_addr | output | ADDR_W | Write-through word address |
| wt_data | output | DATA_W | Write-through data |
| wt_be | output | DATA_W/8 | Write-through byte enables |
| wt_ack | input | 1 | Acknowledge of one earlier write-through |

## Verification
A fault in the merge logic stays hidden until the affected word next leaves the block. It shows up as wrong bytes or enables in the shared cache, or as an extra write-through, after the next global release. A fault in the allocation or drain pointers shows as write-throughs out of arrival order, or as a stall with `st_ready` low that never ends. It appears as soon as the buffer fills. A wrong outstanding count or release state shows within one cycle of the last acknowledgement: `rel_done` pulses early or late, or `st_ready` reopens while the drain is still running.

// File: rtl/wtcb_pkg.sv
`timescale 1ns/1ps
package wtcb_pkg;

    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_DEPTH   = 256;
    localparam int unsigned DEF_MAX_OUT = 8;

    // Release sequencing state
    typedef enum logic {
        SYNC_IDLE  = 1'b0,
        SYNC_FLUSH = 1'b1
    } sync_state_e;

    // Scope encoding on acquire/release requests
    typedef enum logic {
        SCOPE_LOCAL  = 1'b0,
        SCOPE_GLOBAL = 1'b1
    } scope_e;

    // Drain is wanted when a global release is in flight or capacity is exhausted
    function automatic logic drain_wanted(input logic flushing, input logic full);
        return flushing | full;
    endfunction

endpackage

// File: rtl/wtcb_entry_store.sv
`timescale 1ns/1ps
module wtcb_entry_store #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic                  pop,
    output logic                  hit,
    output logic                  hit_head,
    output logic                  full,
    output logic                  empty,
    output logic [ADDR_W-1:0]     head_addr,
    output logic [DATA_W-1:0]     head_data,
    output logic [DATA_W/8-1:0]   head_be
);
    localparam int unsigned BW = DATA_W / 8;
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [BW-1:0]     be;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t          ent_q [DEPTH];
    logic [IW-1:0]   head_q, tail_q, hit_idx;
    logic [CW-1:0]   cnt_q;
    logic [DEPTH-1:0] match;
    logic            do_merge, do_alloc;

    // Associative compare, one comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_q[g].vld && (ent_q[g].addr == wr_addr);
    end

    // At most one slot matches; lowest index wins if ever more
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IW'(i);
        end
    end

    assign hit      = |match;
    assign hit_head = hit && (hit_idx == head_q);
    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign head_addr = ent_q[head_q].addr;
    assign head_data = ent_q[head_q].data;
    assign head_be   = ent_q[head_q].be;

    assign do_merge = wr_en && hit;
    assign do_alloc = wr_en && !hit;

    function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i].vld <= 1'b0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (pop && (head_q == IW'(i))) ent_q[i].vld <= 1'b0;
            end
            if (do_merge) begin
                for (int b = 0; b < BW; b++) begin
                    if (wr_be[b]) ent_q[hit_idx].data[b*8 +: 8] <= wr_data[b*8 +: 8];
                end
                ent_q[hit_idx].be <= ent_q[hit_idx].be | wr_be;
            end
            if (do_alloc) begin
                ent_q[tail_q] <= '{vld: 1'b1, addr: wr_addr, be: wr_be, data: wr_data};
                tail_q <= ptr_inc(tail_q);
            end
            if (pop) head_q <= ptr_inc(head_q);
            cnt_q <= cnt_q + CW'(do_alloc) - CW'(pop);
        end
    end

endmodule

// File: rtl/wtcb_drain.sv
`timescale 1ns/1ps
module wtcb_drain
    import wtcb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned MAX_OUT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                buf_empty,
    input  logic                buf_full,
    input  logic                flushing,
    input  logic [ADDR_W-1:0]   head_addr,
    input  logic [DATA_W-1:0]   head_data,
    input  logic [DATA_W/8-1:0] head_be,
    input  logic                wt_ready,
    input  logic                wt_ack,
    output logic                wt_valid,
    output logic [ADDR_W-1:0]   wt_addr,
    output logic [DATA_W-1:0]   wt_data,
    output logic [DATA_W/8-1:0] wt_be,
    output logic                pop,
    output logic                quiet
);
    localparam int unsigned OW = $clog2(MAX_OUT + 1);

    logic [OW-1:0] out_q;
    logic          credit, ack_ok;

    assign credit   = (out_q < OW'(MAX_OUT));
    assign wt_valid = !buf_empty && drain_wanted(flushing, buf_full) && credit;
    assign pop      = wt_valid && wt_ready;
    assign wt_addr  = head_addr;
    assign wt_data  = head_data;
    assign wt_be    = head_be;
    assign quiet    = (out_q == '0);
    assign ack_ok   = wt_ack && (out_q != '0);

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_q + OW'(pop) - OW'(ack_ok);
    end

endmodule

// File: rtl/wtcb_sync.sv
`timescale 1ns/1ps
module wtcb_sync
    import wtcb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acq_valid,
    input  logic acq_global,
    input  logic rel_valid,
    input  logic rel_global,
    input  logic buf_empty,
    input  logic quiet,
    output logic flushing,
    output logic rel_done,
    output logic l1_inval
);
    sync_state_e state_q;
    logic        loc_done_q, inval_q, glob_done;

    assign flushing  = (state_q == SYNC_FLUSH);
    assign glob_done = flushing && buf_empty && quiet;
    assign rel_done  = loc_done_q | glob_done;
    assign l1_inval  = inval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SYNC_IDLE;
            loc_done_q <= 1'b0;
            inval_q    <= 1'b0;
        end else begin
            loc_done_q <= (state_q == SYNC_IDLE) && rel_valid && (rel_global == SCOPE_LOCAL);
            inval_q    <= acq_valid && (acq_global == SCOPE_GLOBAL);
            case (state_q)
                SYNC_IDLE:  if (rel_valid && (rel_global == SCOPE_GLOBAL)) state_q <= SYNC_FLUSH;
                SYNC_FLUSH: if (glob_done) state_q <= SYNC_IDLE;
                default:    state_q <= SYNC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wt_coalesce_buf.sv
`timescale 1ns/1ps
module wt_coalesce_buf
    import wtcb_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned DEPTH   = DEF_DEPTH,
    parameter int unsigned MAX_OUT = DEF_MAX_OUT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                st_valid,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [DATA_W-1:0]   st_data,
    input  logic [DATA_W/8-1:0] st_be,
    output logic                st_ready,
    input  logic                acq_valid,
    input  logic                acq_global,
    input  logic                rel_valid,
    input  logic                rel_global,
    output logic                rel_done,
    output logic                l1_inval,
    output logic                wt_valid,
    input  logic                wt_ready,
    output logic [ADDR_W-1:0]   wt_addr,
    output logic [DATA_W-1:0]   wt_data,
    output logic [DATA_W/8-1:0] wt_be,
    input  logic                wt_ack
);
    localparam int unsigned BW = DATA_W / 8;

    logic          hit, hit_head, buf_full, buf_empty;
    logic          pop, quiet, flushing, wr_en;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [BW-1:0]     head_be;

    // Hold stores during a global drain, while hitting the offered entry, or missing when full
    assign st_ready = !flushing && !(hit_head && wt_valid) && (hit || !buf_full);
    assign wr_en    = st_valid && st_ready;

    wtcb_entry_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (st_addr),
        .wr_data   (st_data),
        .wr_be     (st_be),
        .pop       (pop),
        .hit       (hit),
        .hit_head  (hit_head),
        .full      (buf_full),
        .empty     (buf_empty),
        .head_addr (head_addr),
        .head_data (head_data),
        .head_be   (head_be)
    );

    wtcb_drain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_OUT(MAX_OUT)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .buf_empty (buf_empty),
        .buf_full  (buf_full),
        .flushing  (flushing),
        .head_addr (head_addr),
        .head_data (head_data),
        .head_be   (head_be),
        .wt_ready  (wt_ready),
        .wt_ack    (wt_ack),
        .wt_valid  (wt_valid),
        .wt_addr   (wt_addr),
        .wt_data   (wt_data),
        .wt_be     (wt_be),
        .pop       (pop),
        .quiet     (quiet)
    );

    wtcb_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .acq_valid  (acq_valid),
        .acq_global (acq_global),
        .rel_valid  (rel_valid),
        .rel_global (rel_global),
        .buf_empty  (buf_empty),
        .quiet      (quiet),
        .flushing   (flushing),
        .rel_done   (rel_done),
        .l1_inval   (l1_inval)
    );

endmodule

// File: rtl/wtcb_checker.sv
`timescale 1ns/1ps
module wtcb_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned MAX_OUT = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                st_ready,
    input logic                acq_valid,
    input logic                acq_global,
    input logic                rel_valid,
    input logic                rel_global,
    input logic                rel_done,
    input logic                l1_inval,
    input logic                wt_valid,
    input logic                wt_ready,
    input logic [ADDR_W-1:0]   wt_addr,
    input logic [DATA_W-1:0]   wt_data,
    input logic [DATA_W/8-1:0] wt_be,
    input logic                wt_ack,
    input logic                buf_full
);
    localparam int unsigned OCW = $clog2(MAX_OUT + 2);

    logic [OCW-1:0] out_c;
    logic           glob_pend;

    // Port-level shadow of unacknowledged write-throughs and of a pending global release
    always_ff @(posedge clk) begin
        if (rst) begin
            out_c     <= '0;
            glob_pend <= 1'b0;
        end else begin
            out_c <= out_c + OCW'(wt_valid && wt_ready) - OCW'(wt_ack && (out_c != '0));
            if (!glob_pend && rel_valid && rel_global) glob_pend <= 1'b1;
            else if (glob_pend && rel_done)            glob_pend <= 1'b0;
        end
    end

    AST_DRAIN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wt_valid |-> (glob_pend || buf_full)); // R2
    AST_REL_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (rel_done && glob_pend) |-> (out_c == '0)); // R5
    AST_STORE_HELD: assert property (@(posedge clk) disable iff (rst)
        glob_pend |-> !st_ready); // R6
    AST_LOCAL_REL: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && !rel_global && !glob_pend) |=> rel_done); // R7
    AST_INV_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (acq_valid && acq_global) |=> l1_inval); // R8
    AST_INV_SCOPE: assert property (@(posedge clk) disable iff (rst)
        l1_inval |-> $past(acq_valid && acq_global)); // R8
    AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        out_c <= OCW'(MAX_OUT)); // R11
    AST_WT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wt_valid && !wt_ready) |=> (wt_valid && $stable(wt_addr) && $stable(wt_data) && $stable(wt_be))); // R12

endmodule

bind wt_coalesce_buf wtcb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_OUT(MAX_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .st_ready   (st_ready),
    .acq_valid  (acq_valid),
    .acq_global (acq_global),
    .rel_valid  (rel_valid),
    .rel_global (rel_global),
    .rel_done   (rel_done),
    .l1_inval   (l1_inval),
    .wt_valid   (wt_valid),
    .wt_ready   (wt_ready),
    .wt_addr    (wt_addr),
    .wt_data    (wt_data),
    .wt_be      (wt_be),
    .wt_ack     (wt_ack),
    .buf_full   (buf_full)
);

// File: tb/sim_wt_coalesce_buf.sv
`timescale 1ns/1ps
module sim_wt_coalesce_buf;
    localparam int AW = 8, DW = 32, BW = 4, DEPTH = 4, MAXO = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic st_valid = 1'b0, st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic acq_valid = 1'b0, acq_global = 1'b0;
    logic rel_valid = 1'b0, rel_global = 1'b0;
    logic rel_done, l1_inval, wt_valid;
    logic wt_ready = 1'b0;
    logic wt_ack = 1'b0;
    logic [AW-1:0] wt_addr;
    logic [DW-1:0] wt_data;
    logic [BW-1:0] wt_be;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] l2_mem [256];
    int          wt_cnt_addr [256];
    logic [7:0]  wt_log [64];
    int          log_n = 0, wt_total = 0, outstanding = 0, max_out = 0;
    logic [3:0]  last_be = '0;
    logic [15:0] ack_pipe = '0;
    int          lat = 1, rdy_mode = 0;

    wt_coalesce_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .MAX_OUT(MAXO)) u0 (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_ready(st_ready),
        .acq_valid(acq_valid), .acq_global(acq_global),
        .rel_valid(rel_valid), .rel_global(rel_global),
        .rel_done(rel_done), .l1_inval(l1_inval),
        .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_addr(wt_addr), .wt_data(wt_data), .wt_be(wt_be),
        .wt_ack(wt_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Downstream acceptance pattern, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0:       wt_ready = 1'b1;
            1:       wt_ready = ~wt_ready;
            default: wt_ready = 1'b0;
        endcase
    end

    // Shared-cache model: observe handshakes at the falling edge, return acks after lat cycles
    always @(negedge clk) begin
        if (!rst) begin
            if (rel_done && outstanding != 0)
                check(1'b0, "R5 rel_done with unacknowledged write-throughs", outstanding, 0);
            wt_ack = ack_pipe[0];
            ack_pipe = ack_pipe >> 1;
            if (wt_ack) outstanding--;
            if (wt_valid && wt_ready) begin
                for (int b = 0; b < BW; b++)
                    if (wt_be[b]) l2_mem[wt_addr][b*8 +: 8] = wt_data[b*8 +: 8];
                wt_cnt_addr[wt_addr]++;
                wt_log[log_n % 64] = wt_addr;
                log_n++;
                wt_total++;
                last_be = wt_be;
                outstanding++;
                ack_pipe[lat-1] = 1'b1;
            end
            if (outstanding > max_out) max_out = outstanding;
        end
    end

    task automatic clear_model();
        for (int i = 0; i < 256; i++) begin
            l2_mem[i] = '0;
            wt_cnt_addr[i] = 0;
        end
        log_n = 0;
        wt_total = 0;
        max_out = 0;
    endtask

    task automatic do_store(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        int guard = 0;
        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        do begin
            @(negedge clk);
            guard++;
        end while (!st_ready && guard < 2000);
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic probe_store(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be, output logic seen);
        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        @(negedge clk);
        seen = st_ready;
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic do_release(input logic glob, output int waited);
        @(posedge clk); #1;
        rel_valid = 1'b1; rel_global = glob;
        @(posedge clk); #1;
        rel_valid = 1'b0;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!rel_done && waited < 2000);
    endtask

    task automatic do_acquire(input logic glob, output logic [2:0] seen);
        @(posedge clk); #1;
        acq_valid = 1'b1; acq_global = glob;
        @(negedge clk);
        seen[0] = l1_inval;
        @(posedge clk); #1;
        acq_valid = 1'b0;
        @(negedge clk);
        seen[1] = l1_inval;
        @(negedge clk);
        seen[2] = l1_inval;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int w;
        int t0;
        logic s;
        logic [2:0] iv;
        logic [31:0] d1, d2, expw;
        logic [7:0] a;
        logic [7:0] exp_order [6];

        clear_model();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(st_ready == 1'b1, "R1 st_ready after reset", st_ready, 1);
        check(wt_valid == 1'b0, "R1 wt_valid after reset", wt_valid, 0);
        check(rel_done == 1'b0, "R1 rel_done after reset", rel_done, 0);
        check(l1_inval == 1'b0, "R1 l1_inval after reset", l1_inval, 0);

        // Sweep all pairs of byte-enable patterns merged into one word (R3, R2)
        for (int be1 = 0; be1 < 16; be1++) begin
            for (int be2 = 0; be2 < 16; be2++) begin
                a = 8'(be1 * 16 + be2);
                d1 = 32'hA0B0C0D0 ^ {24'h0, a};
                d2 = 32'h0F1E2D3C + {24'h0, a};
                rdy_mode = be1 % 2;
                lat = 1 + (be2 % 3);
                t0 = wt_total;
                do_store(a, d1, 4'(be1));
                do_store(a, d2, 4'(be2));
                check(wt_total == t0, "R2 no write-through before release", wt_total, t0);
                do_release(1'b1, w);
                expw = '0;
                for (int b = 0; b < 4; b++) begin
                    if (be2[b])      expw[b*8 +: 8] = d2[b*8 +: 8];
                    else if (be1[b]) expw[b*8 +: 8] = d1[b*8 +: 8];
                end
                check(l2_mem[a] == expw, "R3 merged word in shared cache", l2_mem[a], expw);
                check(wt_cnt_addr[a] == 1, "R3 one write-through per merged word", wt_cnt_addr[a], 1);
                check(last_be == 4'(be1 | be2), "R3 write-through enables are OR of stores", last_be, 4'(be1 | be2));
            end
        end

        // Capacity drain order and re-allocation after eviction (R2, R4, R9, R10)
        rdy_mode = 0; lat = 2;
        repeat (8) @(posedge clk);
        clear_model();
        do_store(8'h10, 32'h1, 4'hF);
        do_store(8'h11, 32'h2, 4'hF);
        do_store(8'h12, 32'h3, 4'hF);
        repeat (5) @(negedge clk);
        check(wt_total == 0, "R2 below capacity holds stores", wt_total, 0);
        do_store(8'h13, 32'h4, 4'hF);
        repeat (5) @(negedge clk);
        check(wt_total == 1, "R9 full buffer drains one entry", wt_total, 1);
        check(wt_log[0] == 8'h10, "R9 full drain takes oldest", wt_log[0], 8'h10);
        do_store(8'h14, 32'h5, 4'hF);
        do_store(8'h10, 32'h6, 4'hF);
        do_release(1'b1, w);
        exp_order[0] = 8'h10; exp_order[1] = 8'h11; exp_order[2] = 8'h12;
        exp_order[3] = 8'h13; exp_order[4] = 8'h14; exp_order[5] = 8'h10;
        check(log_n == 6, "R4 write-through count", log_n, 6);
        for (int i = 0; i < 6; i++)
            check(wt_log[i] == exp_order[i], "R4 write-through order", wt_log[i], exp_order[i]);
        check(wt_cnt_addr[8'h10] == 2, "R10 evicted word written through twice", wt_cnt_addr[8'h10], 2);
        check(l2_mem[8'h10] == 32'h6, "R10 later value reaches shared cache last", l2_mem[8'h10], 32'h6);

        // Backpressure while full (R9, R12)
        repeat (8) @(posedge clk);
        clear_model();
        rdy_mode = 2;
        do_store(8'h20, 32'h20202020, 4'hF);
        do_store(8'h21, 32'h21212121, 4'hF);
        do_store(8'h22, 32'h22222222, 4'hF);
        do_store(8'h23, 32'h33333333, 4'hF);
        @(negedge clk);
        check(wt_valid == 1'b1, "R9 full buffer offers write-through", wt_valid, 1);
        check(wt_addr == 8'h20, "R12 offered address", wt_addr, 8'h20);
        @(negedge clk);
        check(wt_valid == 1'b1 && wt_addr == 8'h20 && wt_data == 32'h20202020,
              "R12 offer held while not accepted", wt_addr, 8'h20);
        probe_store(8'h24, 32'h44444444, 4'hF, s);
        check(s == 1'b0, "R9 miss while full stalls", s, 0);
        probe_store(8'h23, 32'hAAAA0000, 4'b1100, s);
        check(s == 1'b1, "R9 hit while full accepted", s, 1);
        probe_store(8'h20, 32'hFFFFFFFF, 4'hF, s);
        check(s == 1'b0, "R12 hit on offered entry waits", s, 0);
        rdy_mode = 0;
        do_release(1'b1, w);
        check(wt_total == 4, "R9 stalled miss not taken", wt_total, 4);
        check(wt_log[0] == 8'h20 && wt_log[3] == 8'h23, "R4 order after backpressure", wt_log[3], 8'h23);
        check(l2_mem[8'h23] == 32'hAAAA3333, "R3 merge while full", l2_mem[8'h23], 32'hAAAA3333);
        check(l2_mem[8'h20] == 32'h20202020, "R12 held store did not alter offered entry", l2_mem[8'h20], 32'h20202020);

        // Global release completion, store hold-off, outstanding limit (R5, R6, R11)
        repeat (8) @(posedge clk);
        clear_model();
        lat = 6;
        do_store(8'h50, 32'h50, 4'hF);
        do_store(8'h51, 32'h51, 4'hF);
        do_store(8'h52, 32'h52, 4'hF);
        @(posedge clk); #1;
        rel_valid = 1'b1; rel_global = 1'b1;
        @(posedge clk); #1;
        rel_valid = 1'b0;
        probe_store(8'h53, 32'h53, 4'hF, s);
        check(s == 1'b0, "R6 store held during global release", s, 0);
        w = 0;
        while (!rel_done && w < 2000) begin
            @(negedge clk);
            w++;
        end
        check(wt_total == 3, "R5 all entries written before completion", wt_total, 3);
        check(outstanding == 0, "R5 all acknowledged at completion", outstanding, 0);
        check(max_out == MAXO, "R11 outstanding reaches but not exceeds limit", max_out, MAXO);
        probe_store(8'h55, 32'h55, 4'hF, s);
        check(s == 1'b1, "R6 stores resume after completion", s, 1);
        lat = 1;
        do_release(1'b1, w);
        check(wt_cnt_addr[8'h53] == 0, "R6 held store never entered", wt_cnt_addr[8'h53], 0);
        check(wt_cnt_addr[8'h55] == 1, "R6 resumed store written", wt_cnt_addr[8'h55], 1);
        do_release(1'b1, w);
        check(w == 1, "R5 empty global release completes next cycle", w, 1);

        // Local release (R7)
        repeat (4) @(posedge clk);
        clear_model();
        do_store(8'h40, 32'h40, 4'hF);
        do_release(1'b0, w);
        check(w == 1, "R7 local release completes next cycle", w, 1);
        repeat (5) @(negedge clk);
        check(wt_total == 0, "R7 local release writes nothing", wt_total, 0);
        do_release(1'b1, w);
        check(wt_total == 1, "R7 entry kept until global release", wt_total, 1);

        // Acquire scope (R8)
        do_acquire(1'b1, iv);
        check(iv == 3'b010, "R8 global acquire one-cycle strobe next cycle", iv, 3'b010);
        do_acquire(1'b0, iv);
        check(iv == 3'b000, "R8 local acquire no strobe", iv, 3'b000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule